// File: doc/BRIEF.md
# Dual-Source Ready Synchronizer

This block merges two wait-state requests from bus slaves into one ready signal for a processor. Each slave drives a ready request together with an active-low enable. A request counts only while its enable is low, so a slave that is not addressed cannot hold or release the bus. The processor clock is made inside the block from a reference clock at three times its rate. The processor clock is high for one reference cycle and low for two. Every event is timed by a phase count.

A mode input picks the sampling scheme. With mode low, a request must first be captured at a processor-clock rising edge. It reaches the ready output at the falling edge that follows, which gives two stages of synchronization for slaves that are not aligned to the bus. With mode high, the request is taken at the falling edge alone and goes straight to the output. In both modes a request that drops is seen at the next falling edge. The ready output is a register, so it only ever moves at a falling edge of the processor clock.

Top module: `ready_sync`

## Requirements
- R1: The processor clock output has a period of three reference cycles. It is high for one reference cycle and low for two. Its rising edge starts phase 0 and its falling edge starts phase 1.
- R2: Source n (bit n of the request and enable vectors, with source 0 at bit 0) is qualified only while its request bit is 1 and its enable bit is 0. A qualified request asserts ready.
- R3: Ready follows the OR of the qualified requests of both sources, so either source alone can hold it high.
- R4: With mode low, ready rises at a falling edge only if a qualified request was present at the preceding rising edge and is still present at that falling edge. A request that first appears after a rising edge reaches ready one processor cycle later.
- R5: With mode high, ready takes, at each falling edge, the value of the qualified-request OR at that edge.
- R6: At any falling edge where no qualified request is present, ready goes low, whatever the mode.
- R7: The mode input is taken at the falling edge that updates ready. Its value at that edge selects the scheme for that update.
- R8: Ready changes only at processor-clock falling edges. It holds its value through the high phase that follows a rising edge.
- R9: While the active-low reset is asserted, ready is 0 and the processor clock is high (phase 0). Asserting reset forces ready low without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at three times the processor clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| rdyReq | input | 2 | Ready request per source, bit n = source n |
| enN | input | 2 | Active-low enable per source, bit n = source n |
| oneStage | input | 1 | 1 selects falling-edge-only sampling, 0 selects the rising-then-falling path |
| procClk | output | 1 | Derived processor clock |
| ready | output | 1 | Synchronized ready to the processor |

## Verification
The bench applies every stimulus just after a processor-clock rising edge. This is where the two modes differ. A design that skipped the rising-edge stage in mode low would assert ready one cycle early. A design that added a stage in mode high would assert it one cycle late. Each source is tried with its enable high while its request is set. A design that ignored an enable, or that crossed enable bits between sources, would raise ready when it should stay low. Ready is also sampled during the high phase before every falling edge, so a design that updated ready at the rising edge would be caught. A reset pulse is applied while ready is high to check that reset clears it at once.

// File: rtl/ready_sync_pkg.sv
package ready_sync_pkg;

  // Strobes from the phase controller: each is high for the reference cycle
  // whose closing edge is the named processor-clock edge.
  typedef struct packed {
    logic riseStb;
    logic fallStb;
  } edgeStb_t;

endpackage

// File: rtl/ready_sync_ctrl.sv
module ready_sync_ctrl
  import ready_sync_pkg::*;
#(
  parameter int DIV_RATIO   = 3,
  parameter int HIGH_PHASES = 1
) (
  input  logic     clk,
  input  logic     rstN,
  output logic     procClk,
  output edgeStb_t stb
);

  localparam int PH_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(DIV_RATIO - 1);
  localparam logic [PH_W-1:0] FALL_PH = PH_W'(HIGH_PHASES - 1);
  localparam logic [PH_W-1:0] HIGH_LIM = PH_W'(HIGH_PHASES);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign procClk     = (phase < HIGH_LIM);
  assign stb.riseStb = (phase == LAST_PH);
  assign stb.fallStb = (phase == FALL_PH);

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PH);

  assert_fall_timing_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procClk) |-> $past(stb.fallStb));

  assert_rise_timing_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(procClk) |-> $past(stb.riseStb));

endmodule

// File: rtl/ready_sync_dp.sv
module ready_sync_dp
  import ready_sync_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  edgeStb_t           stb,
  input  logic [NUM_SRC-1:0] rdyReq,
  input  logic [NUM_SRC-1:0] enN,
  input  logic               oneStage,
  output logic               ready
);

  logic [NUM_SRC-1:0] qualVec;
  logic               anyReq;
  logic               riseCap;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
    assign qualVec[s] = rdyReq[s] & ~enN[s];
  end

  assign anyReq = |qualVec;

  // First stage: capture at the processor-clock rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            riseCap <= 1'b0;
    else if (stb.riseStb) riseCap <= anyReq;
  end

  // Output stage: only the falling edge updates ready. A missing request
  // always clears it. In two-stage mode the rising-edge capture also has to agree.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ready <= 1'b0;
    else if (stb.fallStb) ready <= anyReq & (oneStage | riseCap);
  end

  assert_ready_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$stable(ready) |-> $past(stb.fallStb));

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.fallStb) && !$past(anyReq) |-> !ready);

  assert_one_stage_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.fallStb && oneStage && anyReq) |-> ready);

  assert_two_stage_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(ready) && !$past(oneStage) |-> $past(riseCap));

  assert_two_stage_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.fallStb && !oneStage && anyReq && riseCap) |-> ready);

endmodule

// File: rtl/ready_sync.sv
module ready_sync
  import ready_sync_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int DIV_RATIO   = 3,
  parameter int HIGH_PHASES = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] rdyReq,
  input  logic [NUM_SRC-1:0] enN,
  input  logic               oneStage,
  output logic               procClk,
  output logic               ready
);

  edgeStb_t stb;

  ready_sync_ctrl #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_PHASES(HIGH_PHASES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .procClk(procClk),
    .stb    (stb)
  );

  ready_sync_dp #(
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rdyReq  (rdyReq),
    .enN     (enN),
    .oneStage(oneStage),
    .ready   (ready)
  );

  assert_reset_R9: assert property (@(posedge clk)
    !rstN |-> !ready && procClk);

endmodule

// File: tb/ready_sync_test.sv
module ready_sync_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rdyReq = 2'b00;
  logic [1:0] enN = 2'b11;
  logic       oneStage = 1'b0;
  logic       procClk;
  logic       ready;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ready_sync uut (
    .clk(clk), .rstN(rstN), .rdyReq(rdyReq), .enN(enN),
    .oneStage(oneStage), .procClk(procClk), .ready(ready)
  );

  // Row fields: {mode, rdy[1:0], enN[1:0], expected ready after the next fall}.
  // Each row is applied just after a rising edge, so the rising-edge capture
  // still holds the qualified request of the row before it.
  localparam logic [5:0] VEC [16] = '{
    6'b0_01_10_0,  // R4: new request, two-stage waits a cycle
    6'b0_01_10_1,  // R4: captured at rise, passes at fall
    6'b0_01_11_0,  // R2/R6: source 0 masked, drops
    6'b0_10_01_0,  // R2: source 1 enabled, first cycle
    6'b0_10_01_1,  // R3: source 1 alone drives ready
    6'b0_10_10_0,  // R2: source 1 masked, source 0 idle
    6'b1_10_00_1,  // R5/R7: one-stage asserts at once
    6'b1_00_00_0,  // R6: one-stage drop
    6'b1_11_11_0,  // R2: both masked
    6'b1_01_10_1,  // R5
    6'b0_01_10_1,  // R7: back to two-stage, held request
    6'b0_11_00_1,  // R3: both sources
    6'b0_00_00_0,  // R6: two-stage drop at fall
    6'b1_11_01_1,  // R2: only source 1 qualified
    6'b0_10_10_0,  // R2: source 1 masked
    6'b0_10_01_0   // R4: fresh request after idle
  };

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prevExp;
    int   hiCnt;
    int   loCnt;

    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check(ready === 1'b0, "R9 ready in reset", ready, 1'b0);
    check(procClk === 1'b1, "R9 procClk in reset", procClk, 1'b1);
    @(negedge clk);
    rstN = 1'b1;

    // R1: clock shape
    @(posedge procClk);
    #1;
    hiCnt = 0;
    while (procClk) begin @(posedge clk); #1; hiCnt++; end
    loCnt = 0;
    while (!procClk) begin @(posedge clk); #1; loCnt++; end
    check(hiCnt == 1, "R1 high width", 1'(hiCnt), 1'b1);
    check(loCnt == 2, "R1 low width", loCnt == 2, 1'b1);

    // Vector walk
    prevExp = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(posedge procClk);
      #1;
      oneStage = VEC[i][5];
      rdyReq   = VEC[i][4:3];
      enN      = VEC[i][2:1];
      check(ready === prevExp, $sformatf("R8 hold before fall row %0d", i), ready, prevExp);
      @(negedge procClk);
      #1;
      check(ready === VEC[i][0], $sformatf("R4 R5 R2 R3 R6 R7 row %0d", i), ready, VEC[i][0]);
      prevExp = VEC[i][0];
    end

    // R9: asynchronous reset clears a high ready
    @(posedge procClk);
    #1;
    oneStage = 1'b1; rdyReq = 2'b01; enN = 2'b10;
    @(negedge procClk);
    #1;
    check(ready === 1'b1, "R5 ready set before reset", ready, 1'b1);
    rstN = 1'b0;
    #1;
    check(ready === 1'b0, "R9 async clear", ready, 1'b0);
    check(procClk === 1'b1, "R9 phase cleared", procClk, 1'b1);
    @(negedge clk);
    rstN = 1'b1;

    // R4: a request that appears after reset needs a rising edge first
    oneStage = 1'b0;
    @(negedge procClk);
    #1;
    check(ready === 1'b0, "R4 no rise capture yet", ready, 1'b0);
    @(negedge procClk);
    #1;
    check(ready === 1'b1, "R4 after rise capture", ready, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule